// File: doc/BRIEF.md
# Per-Channel Test Pattern Injector

This block sits where converter results enter the readout data path, one lane per video channel. For each channel the host picks a source for the data word. It can pass the real converter sample, a running pixel count, a host-written channel identifier, or a blend of the identifier and the count. Because the substitute word rides on that channel's own conversion strobe, the downstream buffers, packers and links see exactly the same beat pattern as in real readout. Faults such as dropped, duplicated or relocated samples then show up as breaks in a known sequence.

Settings are written into a pending copy per channel and only move to the active copy on a frame-start pulse. No frame ever mixes two modes. Each channel keeps a pixel counter that clears at frame start and advances on every strobe, whatever mode the channel is in.

Top module: `test_pattern_injector`

## Requirements
- R1: After reset, every `out_valid` bit, `out_frame_start` and all of `out_data` are 0. Every channel is in mode 0 (converter data), and the identifier of channel k is k.
- R2: Mode is a 2-bit value. In mode 0, a strobe on `adc_strobe[k]` in cycle t makes `out_valid[k]` high in cycle t+1, with `out_data` lane k equal to the `adc_data` lane k of cycle t. In every mode, `out_valid[k]` is `adc_strobe[k]` delayed by one cycle.
- R3: In mode 1 the lane carries the pixel index, counted modulo 2^16. Pixel index 0 is the first strobe at or after frame start.
- R4: In mode 2 the lane carries the channel's full 16-bit identifier.
- R5: In mode 3 the upper 8 bits of the lane are the low 8 bits of the identifier. The lower 8 bits are the low 8 bits of the pixel index.
- R6: The mode, identifier, counter and strobe of one channel have no effect on any other channel's output.
- R7: A write with `cfg_sel`=0 sets the pending mode from `cfg_wdata[1:0]`. A write with `cfg_sel`=1 sets the pending identifier from `cfg_wdata`. In both cases `cfg_chan` selects the channel. Pending values become active on the next `frame_start`. A write in the same cycle as `frame_start` waits for the following one.
- R8: `out_frame_start` equals `frame_start` delayed by one cycle.
- R9: The pixel counter clears at `frame_start`. A strobe in the same cycle as `frame_start` is pixel 0. The counter advances on strobes in every mode, including mode 0.
- R10: A lane's `out_data` holds its value in every cycle that follows a cycle with no strobe on that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_data | input | NCH*DW | Converter results, lane k at bits [k*DW +: DW] |
| adc_strobe | input | NCH | Per-lane conversion strobe |
| frame_start | input | 1 | Frame start pulse, shared by all lanes |
| cfg_we | input | 1 | Configuration write enable |
| cfg_chan | input | CHW | Channel index for the write |
| cfg_sel | input | 1 | 0 = mode field, 1 = identifier field |
| cfg_wdata | input | DW | Write data |
| out_data | output | NCH*DW | Data toward the data path, lane k at bits [k*DW +: DW] |
| out_valid | output | NCH | Per-lane strobe, one cycle after the input strobe |
| out_frame_start | output | 1 | Frame start, one cycle later |

## Verification
The hardest case to reach is the 16-bit counter wrap. It needs more than 65,536 strobes inside one frame with no frame start in between, and random stimulus would never produce such a run. A directed phase therefore holds one lane in counter mode and strobes it on every cycle past the wrap. A second situation that is hard to hit is a configuration write landing on the same cycle as frame start, which must not apply until the next frame. A directed step forces that collision, and random phases with rare frame starts keep many writes pending across frames.

// File: rtl/tpi_pkg.sv
package tpi_pkg;

    typedef enum logic [1:0] {
        SRC_ADC   = 2'b00,
        SRC_COUNT = 2'b01,
        SRC_ID    = 2'b10,
        SRC_MIX   = 2'b11
    } tpi_src_e;

endpackage

// File: rtl/tpi_chan_cfg.sv
module tpi_chan_cfg
    import tpi_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CHW      = 2,
    parameter int CH_INDEX = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_start,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_chan,
    input  logic           cfg_sel,
    input  logic [DW-1:0]  cfg_wdata,
    output tpi_src_e       eff_mode,
    output logic [DW-1:0]  eff_id
);

    typedef struct packed {
        tpi_src_e      pend_mode;
        logic [DW-1:0] pend_id;
        tpi_src_e      act_mode;
        logic [DW-1:0] act_id;
    } cfg_state_t;

    localparam logic [DW-1:0]  RESET_ID = DW'(CH_INDEX);
    localparam logic [CHW-1:0] MY_ADDR  = CHW'(CH_INDEX);

    cfg_state_t r_d, r_q;
    logic       hit;

    always_comb begin
        r_d = r_q;
        hit = cfg_we && (cfg_chan == MY_ADDR);
        // staged copy moves to the active copy only on a frame boundary
        if (frame_start) begin
            r_d.act_mode = r_q.pend_mode;
            r_d.act_id   = r_q.pend_id;
        end
        if (hit && !cfg_sel) begin
            r_d.pend_mode = tpi_src_e'(cfg_wdata[1:0]);
        end
        if (hit && cfg_sel) begin
            r_d.pend_id = cfg_wdata;
        end
        // the frame-start cycle already uses the incoming settings
        eff_mode = frame_start ? r_q.pend_mode : r_q.act_mode;
        eff_id   = frame_start ? r_q.pend_id   : r_q.act_id;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.pend_mode <= SRC_ADC;
            r_q.pend_id   <= RESET_ID;
            r_q.act_mode  <= SRC_ADC;
            r_q.act_id    <= RESET_ID;
        end else begin
            r_q <= r_d;
        end
    end

    // R7: the active settings never move between frame starts
    a_r7_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(r_q.act_mode) && $stable(r_q.act_id)));

    // R7: a write never reaches the active copy in the cycle it lands
    a_r7_write_staged: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && hit) |=> $stable(r_q.act_mode));

endmodule

// File: rtl/tpi_chan_path.sv
module tpi_chan_path
    import tpi_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          strobe,
    input  logic [DW-1:0] adc_word,
    input  tpi_src_e      eff_mode,
    input  logic [DW-1:0] eff_id,
    output logic          out_valid,
    output logic [DW-1:0] out_word
);

    localparam int HALF = DW / 2;

    typedef struct packed {
        logic [DW-1:0] pix_cnt;
        logic [DW-1:0] word;
        logic          valid;
    } path_state_t;

    path_state_t   s_d, s_q;
    logic [DW-1:0] pix_idx;
    logic [DW-1:0] pattern;

    always_comb begin
        s_d     = s_q;
        pix_idx = frame_start ? '0 : s_q.pix_cnt;
        unique case (eff_mode)
            SRC_ADC:   pattern = adc_word;
            SRC_COUNT: pattern = pix_idx;
            SRC_ID:    pattern = eff_id;
            SRC_MIX:   pattern = {eff_id[HALF-1:0], pix_idx[HALF-1:0]};
            default:   pattern = adc_word;
        endcase
        s_d.valid = strobe;
        if (strobe) begin
            s_d.word    = pattern;
            s_d.pix_cnt = pix_idx + 1'b1;
        end else if (frame_start) begin
            s_d.pix_cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.valid;
    assign out_word  = s_q.word;

    // R2: real samples pass through untouched
    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && eff_mode == SRC_ADC) |=> (out_word == $past(adc_word)));

    // R4: identifier mode carries the configured code
    a_r4_id_word: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && eff_mode == SRC_ID) |=> (out_word == $past(eff_id)));

    // R9: a strobe on the frame-start cycle is pixel zero
    a_r9_first_pixel: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && strobe) |=> (s_q.pix_cnt == DW'(1)));

    // R9: the counter only moves on a strobe or a frame start
    a_r9_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !strobe) |=> $stable(s_q.pix_cnt));

    // R10: no strobe, no change on the lane
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(out_word));

endmodule

// File: rtl/test_pattern_injector.sv
module test_pattern_injector
    import tpi_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 16,
    parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*DW-1:0] adc_data,
    input  logic [NCH-1:0]    adc_strobe,
    input  logic              frame_start,
    input  logic              cfg_we,
    input  logic [CHW-1:0]    cfg_chan,
    input  logic              cfg_sel,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [NCH*DW-1:0] out_data,
    output logic [NCH-1:0]    out_valid,
    output logic              out_frame_start
);

    typedef struct packed {
        logic fs;
    } top_state_t;

    top_state_t t_d, t_q;

    always_comb begin
        t_d    = t_q;
        t_d.fs = frame_start;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign out_frame_start = t_q.fs;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        tpi_src_e      mode_w;
        logic [DW-1:0] id_w;

        tpi_chan_cfg #(
            .DW       (DW),
            .CHW      (CHW),
            .CH_INDEX (ch)
        ) u_cfg (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (frame_start),
            .cfg_we      (cfg_we),
            .cfg_chan    (cfg_chan),
            .cfg_sel     (cfg_sel),
            .cfg_wdata   (cfg_wdata),
            .eff_mode    (mode_w),
            .eff_id      (id_w)
        );

        tpi_chan_path #(
            .DW (DW)
        ) u_path (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (frame_start),
            .strobe      (adc_strobe[ch]),
            .adc_word    (adc_data[ch*DW +: DW]),
            .eff_mode    (mode_w),
            .eff_id      (id_w),
            .out_valid   (out_valid[ch]),
            .out_word    (out_data[ch*DW +: DW])
        );
    end

    // R8: frame marker keeps its one-cycle spacing to the data
    a_r8_frame_delay: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> out_frame_start);

    // R2: output beats match input strobes one-for-one
    a_r2_beat_count: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(out_valid) == $countones($past(adc_strobe))));

endmodule

// File: tb/tb_test_pattern_injector.sv
module tb_test_pattern_injector;

    localparam int NCH  = 4;
    localparam int DW   = 16;
    localparam int CHW  = 2;
    localparam int HALF = DW / 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n;
    logic [NCH*DW-1:0] adc_data;
    logic [NCH-1:0]    adc_strobe;
    logic              frame_start;
    logic              cfg_we;
    logic [CHW-1:0]    cfg_chan;
    logic              cfg_sel;
    logic [DW-1:0]     cfg_wdata;
    logic [NCH*DW-1:0] out_data;
    logic [NCH-1:0]    out_valid;
    logic              out_frame_start;

    test_pattern_injector #(.NCH(NCH), .DW(DW), .CHW(CHW)) dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .adc_data        (adc_data),
        .adc_strobe      (adc_strobe),
        .frame_start     (frame_start),
        .cfg_we          (cfg_we),
        .cfg_chan        (cfg_chan),
        .cfg_sel         (cfg_sel),
        .cfg_wdata       (cfg_wdata),
        .out_data        (out_data),
        .out_valid       (out_valid),
        .out_frame_start (out_frame_start)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string phase_tag = "";

    logic [1:0]    m_pm  [NCH];
    logic [1:0]    m_am  [NCH];
    logic [DW-1:0] m_pid [NCH];
    logic [DW-1:0] m_aid [NCH];
    logic [DW-1:0] m_cnt [NCH];
    logic [DW-1:0] e_data[NCH];
    logic          e_val [NCH];
    string         e_tag [NCH];
    logic          e_fs;

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(logic [1:0] m);
        case (m)
            2'd0:    return "R2";
            2'd1:    return "R3/R9";
            2'd2:    return "R4";
            default: return "R5/R9";
        endcase
    endfunction

    function automatic logic [DW-1:0] pattern_of(logic [1:0] m, logic [DW-1:0] adc,
                                                 logic [DW-1:0] id, logic [DW-1:0] pix);
        case (m)
            2'd0:    return adc;
            2'd1:    return pix;
            2'd2:    return id;
            default: return {id[HALF-1:0], pix[HALF-1:0]};
        endcase
    endfunction

    task automatic model_reset();
        for (int ch = 0; ch < NCH; ch++) begin
            m_pm[ch] = 2'd0; m_am[ch] = 2'd0;
            m_pid[ch] = DW'(ch); m_aid[ch] = DW'(ch);
            m_cnt[ch] = '0; e_data[ch] = '0; e_val[ch] = 1'b0; e_tag[ch] = "R1";
        end
        e_fs = 1'b0;
    endtask

    // expected state after the coming clock edge, from the requirements
    task automatic model_step();
        for (int ch = 0; ch < NCH; ch++) begin
            logic [1:0]    em;
            logic [DW-1:0] eid, pix;
            em  = frame_start ? m_pm[ch]  : m_am[ch];
            eid = frame_start ? m_pid[ch] : m_aid[ch];
            pix = frame_start ? '0 : m_cnt[ch];
            e_val[ch] = adc_strobe[ch];
            if (adc_strobe[ch]) begin
                e_data[ch] = pattern_of(em, adc_data[ch*DW +: DW], eid, pix);
                m_cnt[ch]  = pix + 1'b1;
                e_tag[ch]  = req_of(em);
            end else begin
                if (frame_start) m_cnt[ch] = '0;
                e_tag[ch] = "R10";
            end
            if (frame_start) begin
                m_am[ch]  = m_pm[ch];
                m_aid[ch] = m_pid[ch];
            end
            if (cfg_we && cfg_chan == CHW'(ch)) begin
                if (cfg_sel) m_pid[ch] = cfg_wdata;
                else         m_pm[ch]  = cfg_wdata[1:0];
            end
        end
        e_fs = frame_start;
    endtask

    task automatic clear_inputs();
        adc_data = '0; adc_strobe = '0; frame_start = 1'b0;
        cfg_we = 1'b0; cfg_chan = '0; cfg_sel = 1'b0; cfg_wdata = '0;
    endtask

    // inputs are set at the falling edge; checked 1 ns after the rising edge
    task automatic cycle();
        model_step();
        @(posedge clk);
        #1;
        for (int ch = 0; ch < NCH; ch++) begin
            chk({phase_tag, e_tag[ch]}, out_data[ch*DW +: DW], e_data[ch]);
            chk({phase_tag, "R2"}, DW'(out_valid[ch]), DW'(e_val[ch]));
        end
        chk({phase_tag, "R8"}, DW'(out_frame_start), DW'(e_fs));
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic cfg_write(int ch, bit sel, logic [DW-1:0] val);
        cfg_we = 1'b1; cfg_chan = CHW'(ch); cfg_sel = sel; cfg_wdata = val;
    endtask

    task automatic all_strobe();
        adc_strobe = '1;
        for (int ch = 0; ch < NCH; ch++) adc_data[ch*DW +: DW] = DW'($urandom);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        clear_inputs();
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state at the ports
        chk("R1", out_data[DW-1:0], '0);
        chk("R1", out_data[NCH*DW-1 -: DW], '0);
        chk("R1", DW'(out_valid), '0);
        chk("R1", DW'(out_frame_start), '0);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();

        // R1: defaults are mode 0 and identifier = channel index
        phase_tag = "R1 ";
        all_strobe(); cycle();
        frame_start = 1'b1; all_strobe(); cycle();

        // R6/R7: different staged modes per lane, applied only at frame start
        phase_tag = "R6/R7 ";
        cfg_write(1, 1'b0, 16'd1); cycle();
        cfg_write(2, 1'b0, 16'd2); all_strobe(); cycle();
        cfg_write(3, 1'b0, 16'd3); all_strobe(); cycle();
        cfg_write(3, 1'b1, 16'hA5C3); all_strobe(); cycle();
        all_strobe(); cycle();
        frame_start = 1'b1; all_strobe(); cfg_write(0, 1'b0, 16'd2); cycle();
        all_strobe(); cycle();
        adc_strobe = 4'b0101; cycle();
        all_strobe(); cycle();
        cycle();
        frame_start = 1'b1; cycle();
        all_strobe(); cycle();
        all_strobe(); cycle();

        // random traffic with occasional frames and writes
        phase_tag = "";
        for (int i = 0; i < 4000; i++) begin
            frame_start = ($urandom % 48) == 0;
            for (int ch = 0; ch < NCH; ch++) begin
                adc_strobe[ch] = $urandom % 2;
                adc_data[ch*DW +: DW] = DW'($urandom);
            end
            if ($urandom % 8 == 0)
                cfg_write($urandom % NCH, $urandom % 2, DW'($urandom));
            cycle();
        end

        // R3: long frame on lane 0 through the 16-bit wrap
        phase_tag = "R3 ";
        cfg_write(0, 1'b0, 16'd1); cycle();
        frame_start = 1'b1; cycle();
        for (int i = 0; i < 65540; i++) begin
            adc_strobe = 4'b0001;
            adc_data[DW-1:0] = DW'(i);
            cycle();
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule